// File: doc/BRIEF.md
# Majority Reference Key Builder

The block turns many repeated readouts of one fixed-length bit stream into a single reference key. Every readout is 13,120 bits long and arrives as 410 words of 32 bits. For each bit position the block counts how often that position read as one. After a programmed number of accepted readouts, it emits a reference key in which every bit takes the value seen more often at that position. It also reports how many positions were always one, always zero, or changed value at least once.

A readout is a run of words framed by a start flag on its first word and an end flag on its last word. A readout of the wrong length is rejected as a whole. Incoming words go into one of two staging banks. An accepted readout is then folded into the per-bit counters by a read-modify-write pass over the counter memory, while the next readout fills the other bank. A clear command wipes all counters before a new session.

Top module: `mkb_refkey`

## Requirements
- R1: A key bit is 1 only when its ones count is strictly greater than half of `n_target`. An exact tie (count equal to `n_target`/2 with `n_target` even) gives 0.
- R2: The key comes out as 410 words, one per `key_vld` cycle, in stream order starting at word 0. Bit b of key word w covers bit b of the w-th word of each readout. `done` is never high while `key_vld` is high.
- R3: When `done` is high, the totals are valid. A position with count equal to `n_target` adds to `tot_one`, a count of 0 adds to `tot_zero`, and any other count adds to `tot_flip`. The three totals sum to 13,120.
- R4: A readout is accepted only if it has exactly 410 words, from the word with `in_sop` through the word with `in_eor` inclusive. Any other length raises `rej` for one cycle, on the cycle after the end word, and leaves the counters unchanged.
- R5: A valid word that arrives outside a readout (before any `in_sop`, or after an end word) is ignored and does not raise `rej`.
- R6: Once `n_target` readouts have been accepted, further readouts are ignored and do not raise `rej`. `done` stays high until `clr` or `rst`.
- R7: `clr` returns all counters, the accepted-readout count, the totals and `done` to zero.
- R8: Readouts separated by a single idle cycle are all accepted. Folding one readout into the counters overlaps with the arrival of the next.
- R9: After reset, `done`, `key_vld` and `rej` are 0 and all totals are 0.
- R10: No per-bit counter ever wraps. 14-bit counters hold sessions of at least 10,000 readouts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous session clear, same effect as reset |
| n_target | input | 14 | Number of readouts to accumulate (at least 1) |
| in_vld | input | 1 | Input word valid |
| in_sop | input | 1 | First word of a readout |
| in_eor | input | 1 | Last word of a readout |
| in_data | input | 32 | Readout word |
| rej | output | 1 | One-cycle pulse: readout rejected for wrong length |
| key_vld | output | 1 | Reference key word valid |
| key_data | output | 32 | Reference key word |
| tot_one | output | 14 | Positions constant at one |
| tot_zero | output | 14 | Positions constant at zero |
| tot_flip | output | 14 | Positions that took both values |
| done | output | 1 | Key emitted and totals valid |

## Verification
A counter that misses or double-counts a readout shows up as wrong key bits, or as a position moved between the constant and flipping totals. This appears only once the whole session has ended, when the key is emitted after the last accepted readout. Framing errors show up earlier: each mis-judged readout produces a wrong `rej` value one cycle after its end word. A rejected or ignored readout that leaks into the counters is made visible because such readouts carry all-ones data, which corrupts the key and the constant-zero total.

// File: rtl/mkb_pkg.sv
package mkb_pkg;

    localparam int unsigned DEF_WORD_W    = 32;
    localparam int unsigned DEF_NUM_WORDS = 410;
    localparam int unsigned DEF_CNT_W     = 14;

    typedef enum logic [1:0] {
        CLS_ZERO,
        CLS_ONE,
        CLS_FLIP
    } bit_cls_e;

    typedef enum logic [1:0] {
        EM_IDLE,
        EM_RUN,
        EM_DONE
    } em_state_e;

    // strict majority; a tie resolves to zero
    function automatic logic maj_bit(input int unsigned ones, input int unsigned n);
        return (ones * 2) > n;
    endfunction

    function automatic bit_cls_e classify(input int unsigned ones, input int unsigned n);
        if (ones == 0)      return CLS_ZERO;
        else if (ones == n) return CLS_ONE;
        else                return CLS_FLIP;
    endfunction

endpackage

// File: rtl/mkb_capture.sv
module mkb_capture
    import mkb_pkg::*;
#(
    parameter int unsigned WORD_W    = DEF_WORD_W,
    parameter int unsigned NUM_WORDS = DEF_NUM_WORDS,
    parameter int unsigned CNT_W     = DEF_CNT_W,
    localparam int unsigned AW       = $clog2(NUM_WORDS),
    localparam int unsigned CW       = $clog2(NUM_WORDS + 1)
) (
    input  logic              clk,
    input  logic              srst,
    input  logic              in_vld,
    input  logic              in_sop,
    input  logic              in_eor,
    input  logic [WORD_W-1:0] in_data,
    input  logic [CNT_W-1:0]  n_target,
    input  logic              rd_bank,
    input  logic [AW-1:0]     rd_idx,
    output logic [WORD_W-1:0] rd_word,
    output logic              go,
    output logic              go_bank,
    output logic              rej,
    output logic [CNT_W-1:0]  acc_cnt
);

    logic [WORD_W-1:0] stage [2][NUM_WORDS];
    logic              active, ovf, wr_bank;
    logic [CW-1:0]     idx;

    logic              wr_en, ovf_now, frame_ok, end_seen, may_take;
    logic [AW-1:0]     wr_addr;
    logic [CW-1:0]     cnt_now;

    always_comb begin
        wr_en   = 1'b0;
        wr_addr = idx[AW-1:0];
        cnt_now = idx;
        ovf_now = ovf;
        if (in_vld && in_sop) begin
            wr_en   = 1'b1;
            wr_addr = '0;
            cnt_now = CW'(1);
            ovf_now = 1'b0;
        end else if (in_vld && active) begin
            if (idx < CW'(NUM_WORDS)) begin
                wr_en   = 1'b1;
                cnt_now = idx + CW'(1);
            end else begin
                ovf_now = 1'b1;
            end
        end
        frame_ok = (cnt_now == CW'(NUM_WORDS)) && !ovf_now;
        end_seen = in_vld && in_eor && (in_sop || active);
        may_take = acc_cnt < n_target;
    end

    always_ff @(posedge clk) begin
        if (wr_en) stage[wr_bank][wr_addr] <= in_data;
    end

    always_ff @(posedge clk) begin
        if (srst) begin
            active  <= 1'b0;
            ovf     <= 1'b0;
            idx     <= '0;
            wr_bank <= 1'b0;
            go      <= 1'b0;
            go_bank <= 1'b0;
            rej     <= 1'b0;
            acc_cnt <= '0;
        end else begin
            go  <= 1'b0;
            rej <= 1'b0;
            if (in_vld && (in_sop || active)) begin
                active <= !in_eor;
                idx    <= cnt_now;
                ovf    <= ovf_now;
            end
            if (end_seen) begin
                if (!frame_ok) begin
                    rej <= 1'b1;
                end else if (may_take) begin
                    go      <= 1'b1;
                    go_bank <= wr_bank;
                    wr_bank <= ~wr_bank;
                    acc_cnt <= acc_cnt + CNT_W'(1);
                end
            end
        end
    end

    assign rd_word = stage[rd_bank][rd_idx];

    AST_REJ_AFTER_END: assert property (@(posedge clk) disable iff (srst)
        rej |-> $past(in_vld && in_eor)); // R4
    AST_ACC_STEP: assert property (@(posedge clk) disable iff (srst)
        go |-> (acc_cnt == $past(acc_cnt) + CNT_W'(1))); // R8

endmodule

// File: rtl/mkb_accum.sv
module mkb_accum
    import mkb_pkg::*;
#(
    parameter int unsigned WORD_W    = DEF_WORD_W,
    parameter int unsigned NUM_WORDS = DEF_NUM_WORDS,
    parameter int unsigned CNT_W     = DEF_CNT_W,
    localparam int unsigned AW       = $clog2(NUM_WORDS)
) (
    input  logic                          clk,
    input  logic                          srst,
    input  logic                          go,
    input  logic                          go_bank,
    output logic                          stg_bank,
    output logic [AW-1:0]                 stg_idx,
    input  logic [WORD_W-1:0]             stg_word,
    output logic                          busy,
    input  logic [AW-1:0]                 rd_idx,
    output logic [WORD_W-1:0][CNT_W-1:0]  rd_row
);

    localparam logic [AW-1:0] LAST = AW'(NUM_WORDS - 1);

    logic [WORD_W-1:0][CNT_W-1:0] cnt_mem [NUM_WORDS];
    logic [AW-1:0]                idx;
    logic                         bank;

    always_ff @(posedge clk) begin
        if (srst) begin
            busy <= 1'b0;
            idx  <= '0;
            bank <= 1'b0;
            for (int w = 0; w < NUM_WORDS; w++) cnt_mem[w] <= '0;
        end else begin
            if (busy) begin
                for (int b = 0; b < WORD_W; b++)
                    cnt_mem[idx][b] <= cnt_mem[idx][b] + CNT_W'(stg_word[b]);
                idx <= idx + AW'(1);
                if (idx == LAST) busy <= 1'b0;
            end
            if (go) begin
                busy <= 1'b1;
                idx  <= '0;
                bank <= go_bank;
            end
        end
    end

    assign stg_bank = bank;
    assign stg_idx  = idx;
    assign rd_row   = cnt_mem[rd_idx];

    AST_GO_NO_OVERLAP: assert property (@(posedge clk) disable iff (srst)
        go |-> (!busy || idx == LAST)); // R8

    for (genvar gb = 0; gb < WORD_W; gb++) begin : g_wrap
        AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (srst)
            (busy && stg_word[gb]) |-> (cnt_mem[idx][gb] != {CNT_W{1'b1}})); // R10
    end

endmodule

// File: rtl/mkb_emit.sv
module mkb_emit
    import mkb_pkg::*;
#(
    parameter int unsigned WORD_W    = DEF_WORD_W,
    parameter int unsigned NUM_WORDS = DEF_NUM_WORDS,
    parameter int unsigned CNT_W     = DEF_CNT_W,
    localparam int unsigned AW       = $clog2(NUM_WORDS),
    localparam int unsigned TOT_W    = $clog2(NUM_WORDS * WORD_W + 1),
    localparam int unsigned WC_W     = $clog2(WORD_W + 1)
) (
    input  logic                         clk,
    input  logic                         srst,
    input  logic [CNT_W-1:0]             n_target,
    input  logic [CNT_W-1:0]             acc_cnt,
    input  logic                         go,
    input  logic                         busy,
    output logic [AW-1:0]                rd_idx,
    input  logic [WORD_W-1:0][CNT_W-1:0] rd_row,
    output logic                         key_vld,
    output logic [WORD_W-1:0]            key_data,
    output logic [TOT_W-1:0]             tot_one,
    output logic [TOT_W-1:0]             tot_zero,
    output logic [TOT_W-1:0]             tot_flip,
    output logic                         done
);

    localparam logic [AW-1:0] LAST = AW'(NUM_WORDS - 1);

    typedef struct packed {
        logic [WC_W-1:0] one;
        logic [WC_W-1:0] zero;
        logic [WC_W-1:0] flip;
    } word_cls_t;

    em_state_e         state;
    logic [AW-1:0]     idx;
    logic [WORD_W-1:0] key_w;
    word_cls_t         wc;

    always_comb begin
        wc    = '0;
        key_w = '0;
        for (int b = 0; b < WORD_W; b++) begin
            key_w[b] = maj_bit(int'(rd_row[b]), int'(n_target));
            case (classify(int'(rd_row[b]), int'(n_target)))
                CLS_ZERO: wc.zero = wc.zero + WC_W'(1);
                CLS_ONE:  wc.one  = wc.one  + WC_W'(1);
                default:  wc.flip = wc.flip + WC_W'(1);
            endcase
        end
    end

    assign rd_idx = idx;

    always_ff @(posedge clk) begin
        if (srst) begin
            state    <= EM_IDLE;
            idx      <= '0;
            key_vld  <= 1'b0;
            key_data <= '0;
            tot_one  <= '0;
            tot_zero <= '0;
            tot_flip <= '0;
            done     <= 1'b0;
        end else begin
            key_vld <= 1'b0;
            case (state)
                EM_IDLE: begin
                    if (n_target != '0 && acc_cnt == n_target && !go && !busy) begin
                        state <= EM_RUN;
                        idx   <= '0;
                    end
                end
                EM_RUN: begin
                    key_vld  <= 1'b1;
                    key_data <= key_w;
                    tot_one  <= tot_one  + TOT_W'(wc.one);
                    tot_zero <= tot_zero + TOT_W'(wc.zero);
                    tot_flip <= tot_flip + TOT_W'(wc.flip);
                    idx      <= idx + AW'(1);
                    if (idx == LAST) state <= EM_DONE;
                end
                default: done <= 1'b1;
            endcase
        end
    end

    AST_VLD_NOT_DONE: assert property (@(posedge clk) disable iff (srst)
        key_vld |-> !done); // R2
    AST_EMIT_QUIET: assert property (@(posedge clk) disable iff (srst)
        key_vld |-> !busy); // R2
    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (srst)
        done |=> done); // R6
    AST_TOT_SUM: assert property (@(posedge clk) disable iff (srst)
        done |-> (int'(tot_one) + int'(tot_zero) + int'(tot_flip) == NUM_WORDS * WORD_W)); // R3

endmodule

// File: rtl/mkb_refkey.sv
module mkb_refkey
    import mkb_pkg::*;
#(
    parameter int unsigned WORD_W    = DEF_WORD_W,
    parameter int unsigned NUM_WORDS = DEF_NUM_WORDS,
    parameter int unsigned CNT_W     = DEF_CNT_W,
    localparam int unsigned AW       = $clog2(NUM_WORDS),
    localparam int unsigned TOT_W    = $clog2(NUM_WORDS * WORD_W + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic [CNT_W-1:0]  n_target,
    input  logic              in_vld,
    input  logic              in_sop,
    input  logic              in_eor,
    input  logic [WORD_W-1:0] in_data,
    output logic              rej,
    output logic              key_vld,
    output logic [WORD_W-1:0] key_data,
    output logic [TOT_W-1:0]  tot_one,
    output logic [TOT_W-1:0]  tot_zero,
    output logic [TOT_W-1:0]  tot_flip,
    output logic              done
);

    logic                         srst;
    logic                         go, go_bank, busy, stg_bank;
    logic [AW-1:0]                stg_idx, em_idx;
    logic [WORD_W-1:0]            stg_word;
    logic [CNT_W-1:0]             acc_cnt;
    logic [WORD_W-1:0][CNT_W-1:0] row;

    assign srst = rst | clr;

    mkb_capture #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .CNT_W(CNT_W)) u_capture (
        .clk(clk), .srst(srst),
        .in_vld(in_vld), .in_sop(in_sop), .in_eor(in_eor), .in_data(in_data),
        .n_target(n_target),
        .rd_bank(stg_bank), .rd_idx(stg_idx), .rd_word(stg_word),
        .go(go), .go_bank(go_bank), .rej(rej), .acc_cnt(acc_cnt)
    );

    mkb_accum #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .CNT_W(CNT_W)) u_accum (
        .clk(clk), .srst(srst),
        .go(go), .go_bank(go_bank),
        .stg_bank(stg_bank), .stg_idx(stg_idx), .stg_word(stg_word),
        .busy(busy), .rd_idx(em_idx), .rd_row(row)
    );

    mkb_emit #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .CNT_W(CNT_W)) u_emit (
        .clk(clk), .srst(srst),
        .n_target(n_target), .acc_cnt(acc_cnt), .go(go), .busy(busy),
        .rd_idx(em_idx), .rd_row(row),
        .key_vld(key_vld), .key_data(key_data),
        .tot_one(tot_one), .tot_zero(tot_zero), .tot_flip(tot_flip),
        .done(done)
    );

endmodule

// File: tb/mkb_refkey_tb.sv
module mkb_refkey_tb;

    localparam int NW = 410;
    localparam int WW = 32;
    localparam int NB = NW * WW;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        clr = 1'b0;
    logic [13:0] n_target = 14'd1;
    logic        in_vld = 1'b0, in_sop = 1'b0, in_eor = 1'b0;
    logic [31:0] in_data = '0;
    logic        rej, key_vld, done;
    logic [31:0] key_data;
    logic [13:0] tot_one, tot_zero, tot_flip;

    int tests = 0;
    int fails = 0;
    int prob  [NB];
    int ones  [NB];
    int exp_one, exp_zero, exp_flip;
    int popped = 0;
    logic [31:0] exp_q [$];

    always #10 clk = ~clk;

    mkb_refkey u_dut (
        .clk(clk), .rst(rst), .clr(clr), .n_target(n_target),
        .in_vld(in_vld), .in_sop(in_sop), .in_eor(in_eor), .in_data(in_data),
        .rej(rej), .key_vld(key_vld), .key_data(key_data),
        .tot_one(tot_one), .tot_zero(tot_zero), .tot_flip(tot_flip), .done(done)
    );

    task automatic chk(input string req, input longint act, input longint exp, input string what);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // scoreboard monitor: pops expected key words as the design emits them
    always @(negedge clk) begin
        if (key_vld) begin
            if (exp_q.size() == 0) begin
                chk("R2", 1, 0, "unexpected key word");
            end else begin
                logic [31:0] e;
                e = exp_q.pop_front();
                chk("R1", longint'(key_data), longint'(e), $sformatf("key word %0d", popped));
            end
            popped++;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++; tests++;
        $display("FAIL R6 watchdog expired: actual hang expected done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    function automatic void new_session();
        for (int p = 0; p < NB; p++) begin
            int r;
            ones[p] = 0;
            r = $urandom_range(9);
            prob[p] = (r < 5) ? 100 : (r < 8) ? 0 : $urandom_range(99, 1);
        end
    endfunction

    function automatic logic [31:0] gen_word(input int w);
        logic [31:0] v;
        for (int b = 0; b < WW; b++)
            v[b] = ($urandom_range(99) < prob[w*WW + b]);
        return v;
    endfunction

    task automatic send(input int nw, input bit junk, input bit count, output bit rej_seen);
        for (int w = 0; w < nw; w++) begin
            logic [31:0] v;
            @(negedge clk);
            v = junk ? 32'hFFFF_FFFF : gen_word(w % NW);
            if (count)
                for (int b = 0; b < WW; b++) ones[w*WW + b] += int'(v[b]);
            in_vld  = 1'b1;
            in_sop  = (w == 0);
            in_eor  = (w == nw - 1);
            in_data = v;
        end
        @(negedge clk);
        in_vld = 1'b0; in_sop = 1'b0; in_eor = 1'b0;
        rej_seen = rej;
    endtask

    task automatic push_expect(input int n);
        exp_one = 0; exp_zero = 0; exp_flip = 0;
        for (int w = 0; w < NW; w++) begin
            logic [31:0] k;
            for (int b = 0; b < WW; b++) begin
                int c;
                c = ones[w*WW + b];
                k[b] = (2 * c > n);
                if (c == 0) exp_zero++;
                else if (c == n) exp_one++;
                else exp_flip++;
            end
            exp_q.push_back(k);
        end
    endtask

    task automatic finish_session(input string tag);
        while (!done) @(negedge clk);
        chk("R2", popped, NW, {tag, " key words emitted"});
        chk("R2", exp_q.size(), 0, {tag, " words left in queue"});
        chk("R3", tot_one, exp_one, {tag, " constant-one total"});
        chk("R3", tot_zero, exp_zero, {tag, " constant-zero total"});
        chk("R3", tot_flip, exp_flip, {tag, " flipping total"});
        chk("R3", int'(tot_one) + int'(tot_zero) + int'(tot_flip), NB, {tag, " total sum"});
        repeat (5) @(negedge clk);
        chk("R6", done, 1, {tag, " done held"});
        chk("R2", key_vld, 0, {tag, " no key after done"});
    endtask

    initial begin
        bit r;
        repeat (3) @(negedge clk);
        chk("R9", done, 0, "reset done");
        chk("R9", key_vld, 0, "reset key_vld");
        chk("R9", rej, 0, "reset rej");
        chk("R9", int'(tot_one) + int'(tot_zero) + int'(tot_flip), 0, "reset totals");
        rst = 1'b0;

        // session A: N=5, back-to-back, short/long rejects, extra readout ignored
        new_session();
        n_target = 14'd5;
        send(NW, 0, 1, r);       chk("R8", r, 0, "A readout 1 accepted");
        send(NW - 1, 1, 0, r);   chk("R4", r, 1, "A short readout rejected");
        send(NW, 0, 1, r);       chk("R8", r, 0, "A readout 2 accepted");
        send(NW + 1, 1, 0, r);   chk("R4", r, 1, "A long readout rejected");
        send(NW, 0, 1, r);       chk("R4", r, 0, "A readout 3 accepted");
        send(NW, 0, 1, r);       chk("R4", r, 0, "A readout 4 accepted");
        send(NW, 0, 1, r);       chk("R4", r, 0, "A readout 5 accepted");
        push_expect(5);
        send(NW, 1, 0, r);       chk("R6", r, 0, "A readout past N no reject");
        finish_session("A");

        // session B: clear, N=2 (ties), stray words, gaps
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        chk("R7", done, 0, "clear drops done");
        chk("R7", int'(tot_one) + int'(tot_zero) + int'(tot_flip), 0, "clear zeroes totals");
        popped = 0;
        new_session();
        n_target = 14'd2;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            in_vld = 1'b1; in_sop = 1'b0; in_eor = (k == 2); in_data = '1;
        end
        @(negedge clk);
        in_vld = 1'b0; in_eor = 1'b0;
        chk("R5", rej, 0, "B stray words no reject");
        repeat (4) @(negedge clk);
        send(NW, 0, 1, r);       chk("R4", r, 0, "B readout 1 accepted");
        repeat (7) @(negedge clk);
        send(NW, 0, 1, r);       chk("R4", r, 0, "B readout 2 accepted");
        push_expect(2);
        finish_session("B");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule